// File: doc/BRIEF.md
# Mailbox Command Response Engine

This block is the controller-side state machine of a byte-oriented mailbox protocol. The host places a 16-byte request in the mailbox and raises a request-valid pulse. The engine captures the request and decodes the command byte. It answers informational commands from its configuration inputs. Commands that act on the flash window it hands to a separate window manager, after the arguments pass the engine's checks. It then writes a complete 16-byte response image and rings a one-cycle doorbell toward the host.

Every response uses a fixed byte layout. Byte 0 echoes the command and byte 1 echoes the sequence number. Bytes 2 to 12 carry arguments, least significant byte first. Byte 13 carries a result code. Byte 14 echoes the host-owned status byte, and byte 15 carries the controller-owned event byte. The event byte comes from an event register inside the engine. Any source can set its bits through a set input, and the host clears them with an acknowledge command. Bit 0 is set by reset so that the host learns the controller has restarted.

Top module: `mbox_cmd_engine`

## Requirements
- R1: While reset is applied and until the first request is handled, doorbell and win_op_valid are 0, rsp_msg is all zero, and evt_status is 8'h01 (bit 0 means the controller restarted).
- R2: A request is taken only when the engine is idle. A req_valid pulse that arrives while a request is in progress is dropped and never produces a doorbell.
- R3: Each response copies the request's byte 0 (command), byte 1 (sequence number) and byte 14 (host status) into the same bytes of rsp_msg.
- R4: Byte 13 of every response holds a code from 1 to 5 (1 success, 2 parameter error, 3 write error, 4 system error, 5 timeout).
- R5: Command 2 answers success with the following arguments: arg 0 = cfg_api_ver, args 1-2 = cfg_rd_blocks, args 3-4 = cfg_wr_blocks, arg 5 = cfg_blk_shift, and all other argument bytes 0. Arg n sits in byte n+2, and multibyte fields are little-endian.
- R6: Command 3 answers success with args 0-3 = cfg_flash_bytes and args 4-7 = cfg_erase_bytes, both little-endian, and all other argument bytes 0.
- R7: Any command code outside 1..9 answers parameter error (2) with all argument bytes 0 and raises no window operation.
- R8: Commands 1, 4, 5, 6, 7 and 8 that pass their checks raise win_op_valid for exactly one cycle. During that cycle win_op_code carries the command's low 4 bits, win_op_blk carries args 0-1 and win_op_len carries args 2-5. The response then waits for win_done. Its code is win_status when that value is 1..5 and system error (4) otherwise. For commands 4 and 6, args 0-1 of the response carry win_pos, and all other argument bytes are 0.
- R9: Commands 4 and 6 whose block offset (args 0-1) is not below cfg_flash_bytes >> cfg_blk_shift answer parameter error without a window operation. Command 7 with a zero length also answers parameter error. Command 8 with a zero length is passed on to the window manager.
- R10: Every cycle, evt_status takes the bits set on evt_set. Command 9 answers success and clears the bits named in arg 0. A bit that is set and cleared in the same cycle ends up set.
- R11: Byte 15 of each response equals evt_status during the doorbell cycle.
- R12: The doorbell is high for exactly one cycle, and rsp_msg changes only at the edge that starts that cycle. A locally answered request rings in the second cycle after the req_valid cycle. A delegated request rings in the cycle after win_done is sampled, and win_done is sampled from the cycle after win_op_valid onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_msg | input | 128 | Request image, byte n at bits 8n+7:8n |
| cfg_api_ver | input | 8 | Protocol version reported by command 2 |
| cfg_rd_blocks | input | 16 | Read window size in blocks |
| cfg_wr_blocks | input | 16 | Write window size in blocks |
| cfg_blk_shift | input | 8 | Block size as a power of two |
| cfg_flash_bytes | input | 32 | Flash size in bytes |
| cfg_erase_bytes | input | 32 | Erase granule in bytes |
| evt_set | input | 8 | Event bits to set this cycle |
| win_op_valid | output | 1 | One-cycle strobe to the window manager |
| win_op_code | output | 4 | Command being delegated |
| win_op_blk | output | 16 | Block offset or index argument |
| win_op_len | output | 32 | Byte count argument |
| win_done | input | 1 | Window manager finished |
| win_status | input | 8 | Result code from the window manager |
| win_pos | input | 16 | Window position in blocks from the window manager |
| rsp_msg | output | 128 | Response image, byte n at bits 8n+7:8n |
| doorbell | output | 1 | One-cycle interrupt toward the host |
| evt_status | output | 8 | Controller-owned event byte |

## Verification
If the engine leaves its idle state at the wrong time, a doorbell appears with no request behind it or a request goes unanswered. The bench catches this within two cycles of the expected doorbell. A stale captured request shows in the next response as a wrong echoed sequence or host byte. A wrong decode shows as a wrong code in byte 13, a stray or missing win_op_valid in the second cycle after the request, or argument bytes that differ from the configuration. If the event register misbehaves, evt_status diverges on the very next clock, and byte 15 of the next response diverges with it.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int MSG_BYTES = 16;
  localparam int MSG_W     = MSG_BYTES * 8;
  localparam int B_CMD     = 0;
  localparam int B_SEQ     = 1;
  localparam int B_ARG     = 2;
  localparam int B_CODE    = 13;
  localparam int B_HOST    = 14;
  localparam int B_CTRL    = 15;
  localparam int ARG_BYTES = B_CODE - B_ARG;
  localparam int CAP_ARGS  = 6;
  localparam int EVT_W     = 8;
  localparam logic [EVT_W-1:0] EVT_RESET = 8'h01;

  localparam logic [7:0] CMD_RESET      = 8'd1;
  localparam logic [7:0] CMD_MBOX_INFO  = 8'd2;
  localparam logic [7:0] CMD_FLASH_INFO = 8'd3;
  localparam logic [7:0] CMD_OPEN_RD    = 8'd4;
  localparam logic [7:0] CMD_CLOSE      = 8'd5;
  localparam logic [7:0] CMD_OPEN_WR    = 8'd6;
  localparam logic [7:0] CMD_DIRTY      = 8'd7;
  localparam logic [7:0] CMD_FLUSH      = 8'd8;
  localparam logic [7:0] CMD_EVT_ACK    = 8'd9;

  localparam logic [7:0] RC_OK      = 8'd1;
  localparam logic [7:0] RC_PARAM   = 8'd2;
  localparam logic [7:0] RC_SYSTEM  = 8'd4;
  localparam logic [7:0] RC_MAX     = 8'd5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECODE, ST_ISSUE, ST_WAIT, ST_RING
  } st_e;

  typedef logic [MSG_BYTES-1:0][7:0] msg_t;
  typedef logic [ARG_BYTES-1:0][7:0] args_t;

  typedef struct packed {
    logic [7:0]                host;
    logic [CAP_ARGS-1:0][7:0]  arg;
    logic [7:0]                seq;
    logic [7:0]                cmd;
  } req_t;

  function automatic logic code_ok(input logic [7:0] c);
    return (c >= RC_OK) && (c <= RC_MAX);
  endfunction
endpackage

// File: rtl/mbox_rst_sync.sv
module mbox_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
(
  input  req_t        req,
  input  logic [7:0]  cfg_api_ver,
  input  logic [15:0] cfg_rd_blocks,
  input  logic [15:0] cfg_wr_blocks,
  input  logic [7:0]  cfg_blk_shift,
  input  logic [31:0] cfg_flash_bytes,
  input  logic [31:0] cfg_erase_bytes,
  output logic        to_window,
  output logic [7:0]  local_rc,
  output args_t       local_args,
  output logic [7:0]  ack_mask,
  output logic [15:0] op_blk,
  output logic [31:0] op_len
);
  logic [31:0] flash_blocks;

  assign op_blk       = {req.arg[1], req.arg[0]};
  assign op_len       = {req.arg[5], req.arg[4], req.arg[3], req.arg[2]};
  assign flash_blocks = cfg_flash_bytes >> cfg_blk_shift;

  always_comb begin
    to_window  = 1'b0;
    local_rc   = RC_PARAM;
    local_args = '0;
    ack_mask   = '0;
    case (req.cmd)
      CMD_RESET, CMD_CLOSE, CMD_FLUSH: to_window = 1'b1;
      CMD_OPEN_RD, CMD_OPEN_WR: to_window = ({16'd0, op_blk} < flash_blocks);
      CMD_DIRTY: to_window = (op_len != 32'd0);
      CMD_MBOX_INFO: begin
        local_rc      = RC_OK;
        local_args[0] = cfg_api_ver;
        local_args[1] = cfg_rd_blocks[7:0];
        local_args[2] = cfg_rd_blocks[15:8];
        local_args[3] = cfg_wr_blocks[7:0];
        local_args[4] = cfg_wr_blocks[15:8];
        local_args[5] = cfg_blk_shift;
      end
      CMD_FLASH_INFO: begin
        local_rc = RC_OK;
        for (int i = 0; i < 4; i++) begin
          local_args[i]     = cfg_flash_bytes[8*i +: 8];
          local_args[4 + i] = cfg_erase_bytes[8*i +: 8];
        end
      end
      CMD_EVT_ACK: begin
        local_rc = RC_OK;
        ack_mask = req.arg[0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mbox_evt_reg.sv
module mbox_evt_reg
  import mbox_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] set_bits,
  input  logic             clr_en,
  input  logic [EVT_W-1:0] clr_bits,
  output logic [EVT_W-1:0] evt_q,
  output logic [EVT_W-1:0] evt_d
);
  logic [EVT_W-1:0] clr_eff;

  assign clr_eff = clr_en ? clr_bits : '0;
  assign evt_d   = (evt_q & ~clr_eff) | set_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= EVT_RESET;
    else        evt_q <= evt_d;
  end
endmodule

// File: rtl/mbox_rsp_build.sv
module mbox_rsp_build
  import mbox_pkg::*;
(
  input  req_t       req,
  input  logic [7:0] code,
  input  args_t      args,
  input  logic [7:0] evt,
  output msg_t       rsp
);
  always_comb begin
    rsp         = '0;
    rsp[B_CMD]  = req.cmd;
    rsp[B_SEQ]  = req.seq;
    for (int i = 0; i < ARG_BYTES; i++) rsp[B_ARG + i] = args[i];
    rsp[B_CODE] = code;
    rsp[B_HOST] = req.host;
    rsp[B_CTRL] = evt;
  end
endmodule

// File: rtl/mbox_cmd_engine.sv
module mbox_cmd_engine
  import mbox_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic [127:0] req_msg,
  input  logic [7:0]   cfg_api_ver,
  input  logic [15:0]  cfg_rd_blocks,
  input  logic [15:0]  cfg_wr_blocks,
  input  logic [7:0]   cfg_blk_shift,
  input  logic [31:0]  cfg_flash_bytes,
  input  logic [31:0]  cfg_erase_bytes,
  input  logic [7:0]   evt_set,
  output logic         win_op_valid,
  output logic [3:0]   win_op_code,
  output logic [15:0]  win_op_blk,
  output logic [31:0]  win_op_len,
  input  logic         win_done,
  input  logic [7:0]   win_status,
  input  logic [15:0]  win_pos,
  output logic [127:0] rsp_msg,
  output logic         doorbell,
  output logic [7:0]   evt_status
);
  logic        rst_core_n;
  st_e         state_q, state_d;
  req_t        req_in, req_q;
  msg_t        rsp_q, rsp_d;
  logic        req_we, rsp_we, to_window, clr_en;
  logic [7:0]  local_rc, ack_mask, code_sel, evt_q, evt_d;
  args_t       local_args, args_sel;
  logic        unused_req;

  mbox_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_core_n)
  );

  // Only the bytes the protocol reads are captured.
  assign req_in     = {req_msg[8*B_HOST +: 8], req_msg[8*B_ARG +: 8*CAP_ARGS],
                       req_msg[8*B_SEQ +: 8], req_msg[8*B_CMD +: 8]};
  assign unused_req = ^{req_msg[8*B_CTRL +: 8], req_msg[8*(B_ARG+CAP_ARGS) +: 8*(B_HOST-B_ARG-CAP_ARGS)]};

  mbox_decode dec_i (
    .req(req_q), .cfg_api_ver(cfg_api_ver), .cfg_rd_blocks(cfg_rd_blocks),
    .cfg_wr_blocks(cfg_wr_blocks), .cfg_blk_shift(cfg_blk_shift),
    .cfg_flash_bytes(cfg_flash_bytes), .cfg_erase_bytes(cfg_erase_bytes),
    .to_window(to_window), .local_rc(local_rc), .local_args(local_args),
    .ack_mask(ack_mask), .op_blk(win_op_blk), .op_len(win_op_len)
  );

  assign clr_en = (state_q == ST_DECODE) && (req_q.cmd == CMD_EVT_ACK);

  mbox_evt_reg evt_i (
    .clk(clk), .rst_n(rst_core_n), .set_bits(evt_set), .clr_en(clr_en),
    .clr_bits(ack_mask), .evt_q(evt_q), .evt_d(evt_d)
  );

  // Result selection: local answer in DECODE, manager answer in WAIT.
  always_comb begin
    code_sel = local_rc;
    args_sel = local_args;
    if (state_q == ST_WAIT) begin
      code_sel = code_ok(win_status) ? win_status : RC_SYSTEM;
      args_sel = '0;
      if (req_q.cmd == CMD_OPEN_RD || req_q.cmd == CMD_OPEN_WR) begin
        args_sel[0] = win_pos[7:0];
        args_sel[1] = win_pos[15:8];
      end
    end
  end

  mbox_rsp_build rsp_i (
    .req(req_q), .code(code_sel), .args(args_sel), .evt(evt_d), .rsp(rsp_d)
  );

  // Next-state process
  always_comb begin
    state_d = state_q;
    req_we  = 1'b0;
    rsp_we  = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        req_we  = 1'b1;
        state_d = ST_DECODE;
      end
      ST_DECODE: begin
        if (to_window) state_d = ST_ISSUE;
        else begin
          rsp_we  = 1'b1;
          state_d = ST_RING;
        end
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: if (win_done) begin
        rsp_we  = 1'b1;
        state_d = ST_RING;
      end
      ST_RING: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Register processes
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  req_q <= '0;
    else if (req_we)  req_q <= req_in;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  rsp_q <= '0;
    else if (rsp_we)  rsp_q <= rsp_d;
  end

  assign win_op_valid = (state_q == ST_ISSUE);
  assign win_op_code  = req_q.cmd[3:0];
  assign doorbell     = (state_q == ST_RING);
  assign rsp_msg      = rsp_q;
  assign evt_status   = evt_q;
endmodule

// File: rtl/mbox_cmd_engine_chk.sv
module mbox_cmd_engine_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic [127:0] req_msg,
  input logic [127:0] rsp_msg,
  input logic         doorbell,
  input logic         win_op_valid,
  input logic [7:0]   evt_status
);
  logic       pend;
  logic [7:0] seq_c, cmd_c;
  logic       cmd_wm, cmd_bad;
  logic       unused_chk;

  assign unused_chk = ^req_msg[127:16];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      seq_c <= '0;
      cmd_c <= '0;
    end else if (doorbell) begin
      pend <= 1'b0;
    end else if (req_valid && !pend) begin
      pend  <= 1'b1;
      seq_c <= req_msg[15:8];
      cmd_c <= req_msg[7:0];
    end
  end

  assign cmd_wm  = (cmd_c == 8'd1) || (cmd_c == 8'd4) || (cmd_c == 8'd5) ||
                   (cmd_c == 8'd6) || (cmd_c == 8'd7) || (cmd_c == 8'd8);
  assign cmd_bad = (cmd_c == 8'd0) || (cmd_c > 8'd9);

  AST_DB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |=> !doorbell); // R12
  AST_RSP_ONLY_AT_DB: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rsp_msg) |-> doorbell); // R12
  AST_DB_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |-> pend); // R2
  AST_SEQ_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |-> (rsp_msg[15:8] == seq_c && rsp_msg[7:0] == cmd_c)); // R3
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |-> (rsp_msg[111:104] >= 8'd1 && rsp_msg[111:104] <= 8'd5)); // R4
  AST_BAD_CMD_PARAM: assert property (@(posedge clk) disable iff (!rst_n)
    (doorbell && cmd_bad) |-> rsp_msg[111:104] == 8'd2); // R7
  AST_OP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    win_op_valid |=> !win_op_valid); // R8
  AST_OP_ONLY_WINDOW_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    win_op_valid |-> (pend && cmd_wm)); // R8
  AST_EVT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |-> rsp_msg[127:120] == evt_status); // R11
endmodule

bind mbox_cmd_engine mbox_cmd_engine_chk chk_i (
  .clk(clk), .rst_n(rst_core_n), .req_valid(req_valid), .req_msg(req_msg),
  .rsp_msg(rsp_msg), .doorbell(doorbell), .win_op_valid(win_op_valid),
  .evt_status(evt_status)
);

// File: tb/mbox_cmd_engine_tb_top.sv
module mbox_cmd_engine_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid;
  logic [127:0] req_msg;
  logic [7:0]   cfg_api_ver;
  logic [15:0]  cfg_rd_blocks, cfg_wr_blocks;
  logic [7:0]   cfg_blk_shift;
  logic [31:0]  cfg_flash_bytes, cfg_erase_bytes;
  logic [7:0]   evt_set;
  logic         win_op_valid;
  logic [3:0]   win_op_code;
  logic [15:0]  win_op_blk;
  logic [31:0]  win_op_len;
  logic         win_done;
  logic [7:0]   win_status;
  logic [15:0]  win_pos;
  logic [127:0] rsp_msg;
  logic         doorbell;
  logic [7:0]   evt_status;

  int vectors = 0;
  int fails   = 0;
  bit cmp_on  = 1'b0;

  always #4 clk = ~clk;

  mbox_cmd_engine dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_msg(req_msg),
    .cfg_api_ver(cfg_api_ver), .cfg_rd_blocks(cfg_rd_blocks),
    .cfg_wr_blocks(cfg_wr_blocks), .cfg_blk_shift(cfg_blk_shift),
    .cfg_flash_bytes(cfg_flash_bytes), .cfg_erase_bytes(cfg_erase_bytes),
    .evt_set(evt_set), .win_op_valid(win_op_valid), .win_op_code(win_op_code),
    .win_op_blk(win_op_blk), .win_op_len(win_op_len), .win_done(win_done),
    .win_status(win_status), .win_pos(win_pos), .rsp_msg(rsp_msg),
    .doorbell(doorbell), .evt_status(evt_status)
  );

  task automatic fail(input string tag, input logic [127:0] act, input logic [127:0] exp);
    fails++;
    $display("FAIL %s: actual %h expected %h", tag, act, exp);
  endtask

  // Expected local answer; returns 1 when the request goes to the window manager.
  function automatic bit model_local(input logic [127:0] r, output logic [7:0] rc,
                                     output logic [87:0] a);
    int     cmd;
    longint blk, len, fblk;
    cmd  = int'(r[7:0]);
    blk  = longint'(r[31:16]);
    len  = longint'(r[63:32]);
    fblk = longint'(cfg_flash_bytes) >> cfg_blk_shift;
    rc   = 8'd2;
    a    = '0;
    model_local = 1'b0;
    case (cmd)
      1, 5, 8: model_local = 1'b1;
      4, 6:    model_local = (blk < fblk);
      7:       model_local = (len != 0);
      2: begin
        rc = 8'd1;
        a[7:0] = cfg_api_ver; a[23:8] = cfg_rd_blocks;
        a[39:24] = cfg_wr_blocks; a[47:40] = cfg_blk_shift;
      end
      3: begin
        rc = 8'd1;
        a[31:0] = cfg_flash_bytes; a[63:32] = cfg_erase_bytes;
      end
      9: rc = 8'd1;
      default: ;
    endcase
  endfunction

  // Behavioural reference: phase 0 idle, 1 decode, 2 issue, 3 wait, 4 ring
  int           m_ph;
  logic [127:0] m_req, e_rsp;
  logic [7:0]   m_evt;
  logic         e_db, e_wop;

  always @(posedge clk or negedge rst_n) begin
    logic [7:0]  nevt, lrc, rc;
    logic [87:0] la, ra;
    bit          fire;
    if (!rst_n) begin
      m_ph = 0; m_req = '0; e_rsp = '0; m_evt = 8'h01; e_db = 1'b0; e_wop = 1'b0;
    end else begin
      fire = 1'b0; rc = '0; ra = '0; nevt = m_evt;
      case (m_ph)
        0: if (req_valid) begin m_req = req_msg; m_ph = 1; end
        1: begin
          if (model_local(m_req, lrc, la)) m_ph = 2;
          else begin fire = 1'b1; rc = lrc; ra = la; end
          if (m_req[7:0] == 8'd9) nevt = nevt & ~m_req[23:16];
        end
        2: m_ph = 3;
        3: if (win_done) begin
          fire = 1'b1;
          rc = (win_status >= 8'd1 && win_status <= 8'd5) ? win_status : 8'd4;
          if (m_req[7:0] == 8'd4 || m_req[7:0] == 8'd6) ra[15:0] = win_pos;
        end
        default: m_ph = 0;
      endcase
      nevt  = nevt | evt_set;
      m_evt = nevt;
      if (fire) begin
        e_rsp = {nevt, m_req[119:112], rc, ra, m_req[15:8], m_req[7:0]};
        m_ph  = 4;
      end
      e_db  = (m_ph == 4);
      e_wop = (m_ph == 2);
    end
  end

  function automatic string code_tag(input logic [7:0] c);
    if (c == 8'd4 || c == 8'd6 || c == 8'd7) return "R9";
    if (c == 8'd0 || c > 8'd9) return "R7";
    return "R4";
  endfunction

  function automatic string arg_tag(input logic [7:0] c);
    if (c == 8'd2) return "R5";
    if (c == 8'd3) return "R6";
    if (c == 8'd4 || c == 8'd6) return "R8";
    if (c == 8'd9) return "R10";
    return "R7";
  endfunction

  // Compare every clock, away from the active edge
  always @(negedge clk) if (cmp_on) begin
    vectors++;
    if (doorbell !== e_db) fail(e_db ? "R12" : "R2", 128'(doorbell), 128'(e_db));
    if (win_op_valid !== e_wop)
      fail((m_req[7:0] == 8'd4 || m_req[7:0] == 8'd6 || m_req[7:0] == 8'd7) ? "R9" : "R8",
           128'(win_op_valid), 128'(e_wop));
    if (e_wop && {win_op_code, win_op_blk, win_op_len} !== {m_req[3:0], m_req[31:16], m_req[63:32]})
      fail("R8", 128'({win_op_code, win_op_blk, win_op_len}), 128'({m_req[3:0], m_req[31:16], m_req[63:32]}));
    if (evt_status !== m_evt) fail("R10", 128'(evt_status), 128'(m_evt));
    if ({rsp_msg[119:112], rsp_msg[15:0]} !== {e_rsp[119:112], e_rsp[15:0]})
      fail("R3", 128'({rsp_msg[119:112], rsp_msg[15:0]}), 128'({e_rsp[119:112], e_rsp[15:0]}));
    if (rsp_msg[111:104] !== e_rsp[111:104])
      fail(code_tag(e_rsp[7:0]), 128'(rsp_msg[111:104]), 128'(e_rsp[111:104]));
    if (rsp_msg[103:16] !== e_rsp[103:16])
      fail(arg_tag(e_rsp[7:0]), 128'(rsp_msg[103:16]), 128'(e_rsp[103:16]));
    if (rsp_msg[127:120] !== e_rsp[127:120])
      fail("R11", 128'(rsp_msg[127:120]), 128'(e_rsp[127:120]));
  end

  // One request; the bench plays the window manager when win_op_valid appears.
  task automatic send(input logic [7:0] cmd, input logic [7:0] seq, input logic [87:0] args,
                      input logic [7:0] evt_in, input bit inject, input int dly,
                      input logic [7:0] st, input logic [15:0] pos);
    @(negedge clk);
    req_valid = 1'b1;
    req_msg   = {8'hEE, seq ^ 8'h3C, 8'h5A, args, seq, cmd};
    @(negedge clk);
    req_valid = 1'b0;
    evt_set   = evt_in;
    @(negedge clk);
    evt_set   = 8'h00;
    if (win_op_valid) begin
      @(negedge clk);
      if (inject) begin
        req_valid = 1'b1;
        req_msg   = {16{8'h77}};
      end
      for (int i = 0; i < dly; i++) begin
        @(negedge clk);
        req_valid = 1'b0;
      end
      req_valid  = 1'b0;
      win_done   = 1'b1;
      win_status = st;
      win_pos    = pos;
      @(negedge clk);
      win_done   = 1'b0;
    end
    for (int i = 0; i < 4 && !doorbell; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_evt(input logic [7:0] v);
    @(negedge clk); evt_set = v;
    @(negedge clk); evt_set = 8'h00;
  endtask

  function automatic logic [87:0] wargs(input logic [15:0] blk, input logic [31:0] len);
    return {40'd0, len, blk};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_msg = '0; evt_set = '0;
    win_done = 1'b0; win_status = '0; win_pos = '0;
    cfg_api_ver = 8'h03; cfg_rd_blocks = 16'h0120; cfg_wr_blocks = 16'h0011;
    cfg_blk_shift = 8'd12; cfg_flash_bytes = 32'h0200_0000; cfg_erase_bytes = 32'h0000_1000;
    repeat (4) @(negedge clk);
    // R1: reset values
    vectors++;
    if ({doorbell, win_op_valid} !== 2'b00) fail("R1", 128'({doorbell, win_op_valid}), 128'(0));
    vectors++;
    if (rsp_msg !== '0) fail("R1", rsp_msg, '0);
    vectors++;
    if (evt_status !== 8'h01) fail("R1", 128'(evt_status), 128'(8'h01));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1'b1;

    send(8'd2, 8'h11, 88'h00_1234_5678_9ABC_DEF0_1122, 8'h00, 0, 0, 0, 0);  // R5, R3
    send(8'd3, 8'h12, '0, 8'h00, 0, 0, 0, 0);                               // R6
    send(8'd9, 8'h13, 88'h01, 8'h00, 0, 0, 0, 0);                           // R10 clears restart bit
    send(8'd0, 8'h14, 88'hFF_FFFF, 8'h00, 0, 0, 0, 0);                      // R7
    send(8'd200, 8'h15, 88'h0F, 8'h00, 0, 0, 0, 0);                         // R7
    send(8'd4, 8'h16, wargs(16'd5, 0), 8'h00, 0, 2, 8'd1, 16'h1234);        // R8 position echo
    send(8'd6, 8'h17, wargs(16'd8192, 0), 8'h00, 0, 0, 0, 0);               // R9 offset at limit
    send(8'd6, 8'h18, wargs(16'd8191, 0), 8'h00, 0, 0, 8'd1, 16'hBEEF);     // R9 offset below limit
    send(8'd7, 8'h19, wargs(16'd1, 0), 8'h00, 0, 0, 0, 0);                  // R9 zero dirty length
    send(8'd7, 8'h1A, wargs(16'd2, 32'h200), 8'h00, 0, 1, 8'd3, 0);         // R8 write error passes
    send(8'd8, 8'h1B, wargs(16'd0, 0), 8'h00, 0, 4, 8'd5, 0);               // R9 zero flush allowed
    send(8'd5, 8'h1C, '0, 8'h00, 0, 0, 8'd0, 0);                            // R8 bad status -> system
    send(8'd1, 8'h1D, '0, 8'h00, 0, 0, 8'd9, 0);                            // R8 bad status -> system
    send(8'd5, 8'h1E, '0, 8'h00, 1, 3, 8'd1, 0);                            // R2 request while busy
    pulse_evt(8'h06);                                                       // R10 set from idle
    send(8'd9, 8'h1F, 88'h02, 8'h02, 0, 0, 0, 0);                           // R10 set wins, R11
    send(8'd9, 8'h20, 88'h06, 8'h00, 0, 0, 0, 0);                           // R10, R11
    cfg_blk_shift = 8'd16;
    send(8'd4, 8'h21, wargs(16'd512, 0), 8'h00, 0, 0, 0, 0);                // R9 smaller flash in blocks
    send(8'd2, 8'h22, '0, 8'h00, 0, 0, 0, 0);                               // R5 new shift, R12
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule